// File: doc/BRIEF.md
# Branch Resolve and Next-PC Unit

This unit sits beside the execute stage of a 64-bit RISC core that uses fixed 32-bit instruction words. It takes one instruction word, the address it was fetched from, the two register operands the instruction names, and a small bank of one-bit condition flags. It then settles whether the instruction transfers control, whether that transfer happens, and where execution continues. For the two linking jumps it also supplies the return address and the register that should receive it.

The register indices the instruction names are decoded straight from the word and leave the block without any register in between, so the register file can return the operands in the same cycle. The full result (next address, taken, branch flag, link write) is captured in output registers and shown one clock after the request, with `out_valid` as the qualifier. Register storage, fetch and every non-control instruction belong to other blocks.

Top module: `branch_resolve_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low after a cycle with `in_valid` low. A synchronous `rst` clears `out_valid`.
- R2: The major opcode is `inst[31:26]`. Codes 0x10 to 0x1B are recognised as described below. Any other code gives `is_branch`=0, `taken`=0, `link_we`=0 and `next_pc`=pc+4.
- R3: Major code 0x12 is a flag branch when `inst[9:8]` is 00 (taken if the flag is 0) or 01 (taken if the flag is 1). The flag number is `inst[7:5]`. With `inst[9:8]` at 10 or 11 it counts as a non-branch. The flag branch uses the 21-bit offset.
- R4: 0x10 is taken when operand A is zero and 0x11 when it is nonzero. The target is pc plus the offset {inst[4:0], inst[25:10]}, shifted left by 2 and sign-extended from bit 22.
- R5: 0x16 is taken when A equals B and 0x17 when they differ. The target is pc plus inst[25:10], shifted left by 2 and sign-extended from bit 17.
- R6: 0x18 is taken when A < B as signed values and 0x19 when A >= B as signed values. Both use the 16-bit offset.
- R7: 0x1A is taken when A < B as unsigned values and 0x1B when A >= B as unsigned values. Both use the 16-bit offset.
- R8: A recognised conditional branch that is not taken gives `next_pc`=pc+4 and `is_branch`=1.
- R9: 0x14 is always taken to pc plus {inst[9:0], inst[25:10]}, shifted left by 2 and sign-extended from bit 27. It has no link write.
- R10: 0x15 jumps like 0x14 and writes pc+4 to register 1 (`link_we`=1, `link_idx`=1).
- R11: 0x13 is always taken to operand A plus the 16-bit offset. Its link index is `inst[4:0]`. `link_data` is always pc+4.
- R12: A link write aimed at register 0 has `link_we` low.
- R13: `rj_idx` equals `inst[9:5]` and `rd_idx` equals `inst[4:0]` in the same cycle, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request qualifier |
| inst | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| opnd_a | input | 64 | Value of register `rj_idx` |
| opnd_b | input | 64 | Value of register `rd_idx` |
| flags | input | 8 | Condition flag bank |
| rj_idx | output | 5 | First source register index (combinational) |
| rd_idx | output | 5 | Second source / link register index (combinational) |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| next_pc | output | 64 | Address of the next instruction |
| taken | output | 1 | Control transfer happens |
| is_branch | output | 1 | Instruction is a recognised control transfer |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_data | output | 64 | Return address, pc+4 |

## Verification
The only state in the block is the output register stage. A bad captured value therefore shows up at the ports in the very cycle `out_valid` rises, and it is replaced on the next accepted request. A wrong decode shows up as a wrong `is_branch` or link field. A wrong sign or comparator choice shows up as a `next_pc` that is off by the offset or stuck at pc+4. The unsigned and signed comparisons are driven with operands whose top bits differ, so that a swapped or shared comparator that picks the wrong sign extension changes `taken` at once.

// File: rtl/bru_pkg.sv
package bru_pkg;

   // Major opcode values; decode priority and field meanings depend on them
   localparam logic [5:0] OPC_EQZ  = 6'h10;
   localparam logic [5:0] OPC_NEZ  = 6'h11;
   localparam logic [5:0] OPC_FLAG = 6'h12;
   localparam logic [5:0] OPC_JIRL = 6'h13;
   localparam logic [5:0] OPC_B    = 6'h14;
   localparam logic [5:0] OPC_BL   = 6'h15;
   localparam logic [5:0] OPC_EQ   = 6'h16;
   localparam logic [5:0] OPC_NE   = 6'h17;
   localparam logic [5:0] OPC_LT   = 6'h18;
   localparam logic [5:0] OPC_GE   = 6'h19;
   localparam logic [5:0] OPC_LTU  = 6'h1A;
   localparam logic [5:0] OPC_GEU  = 6'h1B;

   typedef enum logic [3:0] {
      K_NONE, K_EQZ, K_NEZ, K_FEQZ, K_FNEZ, K_JIRL, K_B, K_BL,
      K_EQ, K_NE, K_LT, K_GE, K_LTU, K_GEU
   } br_kind_e;

   typedef enum logic [1:0] {
      OFF_16, OFF_21, OFF_26
   } off_sel_e;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
   import bru_pkg::*;
#(
   parameter int ILEN   = 32,
   parameter int XLEN   = 64,
   parameter int FIDX_W = 3
) (
   input  logic [ILEN-1:0]   inst,
   output br_kind_e          kind,
   output logic [4:0]        rj_idx,
   output logic [4:0]        rd_idx,
   output logic [FIDX_W-1:0] flag_idx,
   output logic [XLEN-1:0]   imm
);

   localparam int SX16 = XLEN - 18;
   localparam int SX21 = XLEN - 23;
   localparam int SX26 = XLEN - 28;

   if (ILEN != 32) begin : g_ilen_chk
      $error("bru_decode: ILEN must be 32");
   end
   if (FIDX_W < 1 || FIDX_W > 3) begin : g_fidx_chk
      $error("bru_decode: flag index width must be 1..3");
   end

   logic [5:0] opc;
   off_sel_e   osel;
   logic [XLEN-1:0] imm16, imm21, imm26;

   assign opc      = inst[31:26];
   assign rj_idx   = inst[9:5];
   assign rd_idx   = inst[4:0];
   assign flag_idx = inst[5+FIDX_W-1:5];

   assign imm16 = {{SX16{inst[25]}}, inst[25:10], 2'b00};
   assign imm21 = {{SX21{inst[4]}},  inst[4:0], inst[25:10], 2'b00};
   assign imm26 = {{SX26{inst[9]}},  inst[9:0], inst[25:10], 2'b00};

   always_comb begin
      kind = K_NONE;
      osel = OFF_16;
      case (opc)
         OPC_EQZ:  begin kind = K_EQZ; osel = OFF_21; end
         OPC_NEZ:  begin kind = K_NEZ; osel = OFF_21; end
         OPC_FLAG: begin
            osel = OFF_21;
            case (inst[9:8])
               2'b00:   kind = K_FEQZ;
               2'b01:   kind = K_FNEZ;
               default: kind = K_NONE;
            endcase
         end
         OPC_JIRL: kind = K_JIRL;
         OPC_B:    begin kind = K_B;  osel = OFF_26; end
         OPC_BL:   begin kind = K_BL; osel = OFF_26; end
         OPC_EQ:   kind = K_EQ;
         OPC_NE:   kind = K_NE;
         OPC_LT:   kind = K_LT;
         OPC_GE:   kind = K_GE;
         OPC_LTU:  kind = K_LTU;
         OPC_GEU:  kind = K_GEU;
         default:  kind = K_NONE;
      endcase
   end

   always_comb begin
      case (osel)
         OFF_21:  imm = imm21;
         OFF_26:  imm = imm26;
         default: imm = imm16;
      endcase
   end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
   import bru_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int NFLAG      = 8,
   parameter int FIDX_W     = 3,
   parameter bit SHARED_CMP = 1'b1
) (
   input  br_kind_e          kind,
   input  logic [XLEN-1:0]   opnd_a,
   input  logic [XLEN-1:0]   opnd_b,
   input  logic [NFLAG-1:0]  flags,
   input  logic [FIDX_W-1:0] flag_idx,
   output logic              take
);

   if (NFLAG != (1 << FIDX_W)) begin : g_nflag_chk
      $error("bru_cond: NFLAG must equal 2**FIDX_W");
   end

   logic a_zero, eq, lt_s, lt_u, flag_bit;

   assign a_zero   = (opnd_a == '0);
   assign eq       = (opnd_a == opnd_b);
   assign flag_bit = flags[flag_idx];

   if (SHARED_CMP) begin : g_shared
      // One XLEN+1 bit subtractor; the extension bit picks signedness
      logic          sgn;
      logic [XLEN:0] diff;
      logic          lt_any;
      assign sgn    = (kind == K_LT) || (kind == K_GE);
      assign diff   = {sgn & opnd_a[XLEN-1], opnd_a} - {sgn & opnd_b[XLEN-1], opnd_b};
      assign lt_any = diff[XLEN];
      assign lt_s   = lt_any;
      assign lt_u   = lt_any;
   end else begin : g_split
      assign lt_s = ($signed(opnd_a) < $signed(opnd_b));
      assign lt_u = (opnd_a < opnd_b);
   end

   always_comb begin
      case (kind)
         K_EQZ:  take = a_zero;
         K_NEZ:  take = !a_zero;
         K_FEQZ: take = !flag_bit;
         K_FNEZ: take = flag_bit;
         K_JIRL, K_B, K_BL: take = 1'b1;
         K_EQ:   take = eq;
         K_NE:   take = !eq;
         K_LT:   take = lt_s;
         K_GE:   take = !lt_s;
         K_LTU:  take = lt_u;
         K_GEU:  take = !lt_u;
         default: take = 1'b0;
      endcase
   end

endmodule

// File: rtl/bru_target.sv
module bru_target
   import bru_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int ISIZE = 4
) (
   input  br_kind_e        kind,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] imm,
   input  logic            take,
   output logic [XLEN-1:0] next_pc,
   output logic [XLEN-1:0] seq_pc
);

   logic [XLEN-1:0] base, tgt;

   assign base    = (kind == K_JIRL) ? opnd_a : pc;
   assign tgt     = base + imm;
   assign seq_pc  = pc + XLEN'(ISIZE);
   assign next_pc = take ? tgt : seq_pc;

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
   import bru_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int ILEN       = 32,
   parameter int NFLAG      = 8,
   parameter int LINK_REG   = 1,
   parameter bit SHARED_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [ILEN-1:0]  inst,
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  opnd_b,
   input  logic [NFLAG-1:0] flags,
   output logic [4:0]       rj_idx,
   output logic [4:0]       rd_idx,
   output logic             out_valid,
   output logic [XLEN-1:0]  next_pc,
   output logic             taken,
   output logic             is_branch,
   output logic             link_we,
   output logic [4:0]       link_idx,
   output logic [XLEN-1:0]  link_data
);

   localparam int FIDX_W = $clog2(NFLAG);

   if (XLEN < 32) begin : g_xlen_chk
      $error("branch_resolve_unit: XLEN must be at least 32");
   end
   if (LINK_REG < 1 || LINK_REG > 31) begin : g_link_chk
      $error("branch_resolve_unit: LINK_REG must be 1..31");
   end

   br_kind_e          kind;
   logic [FIDX_W-1:0] flag_idx;
   logic [XLEN-1:0]   imm, npc_c, seq_c;
   logic              take_c, link_we_c;
   logic [4:0]        link_idx_c;

   bru_decode #(.ILEN(ILEN), .XLEN(XLEN), .FIDX_W(FIDX_W)) u_dec (
      .inst(inst), .kind(kind), .rj_idx(rj_idx), .rd_idx(rd_idx),
      .flag_idx(flag_idx), .imm(imm)
   );

   bru_cond #(.XLEN(XLEN), .NFLAG(NFLAG), .FIDX_W(FIDX_W), .SHARED_CMP(SHARED_CMP)) u_cond (
      .kind(kind), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags(flags),
      .flag_idx(flag_idx), .take(take_c)
   );

   bru_target #(.XLEN(XLEN), .ISIZE(ILEN/8)) u_tgt (
      .kind(kind), .pc(pc), .opnd_a(opnd_a), .imm(imm), .take(take_c),
      .next_pc(npc_c), .seq_pc(seq_c)
   );

   always_comb begin
      case (kind)
         K_JIRL:  link_idx_c = rd_idx;
         K_BL:    link_idx_c = 5'(LINK_REG);
         default: link_idx_c = 5'd0;
      endcase
      link_we_c = ((kind == K_JIRL) || (kind == K_BL)) && (link_idx_c != 5'd0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         next_pc   <= '0;
         taken     <= 1'b0;
         is_branch <= 1'b0;
         link_we   <= 1'b0;
         link_idx  <= '0;
         link_data <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            next_pc   <= npc_c;
            taken     <= take_c;
            is_branch <= (kind != K_NONE);
            link_we   <= link_we_c;
            link_idx  <= link_idx_c;
            link_data <= seq_c;
         end
      end
   end

   // R1: result qualifier tracks the request qualifier with one cycle of latency
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R2: a non-branch never reports a transfer or a link write
   a_r2_nonbranch_quiet: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !is_branch) |-> (!taken && !link_we));
   // R8: a fall-through result continues at the return address
   a_r8_fallthrough_seq: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !taken) |-> (next_pc == link_data));
   // R10: the linking relative jump writes the fixed link register
   a_r10_bl_link: assert property (@(posedge clk) disable iff (rst)
      (in_valid && inst[31:26] == OPC_BL) |=> (taken && link_we && link_idx == 5'(LINK_REG)));
   // R12: register 0 is never written
   a_r12_no_zero_link: assert property (@(posedge clk) disable iff (rst)
      (out_valid && link_we) |-> (link_idx != 5'd0));
   // R12: an enabled link write only comes from a recognised transfer
   a_r12_link_needs_branch: assert property (@(posedge clk) disable iff (rst)
      (out_valid && link_we) |-> (is_branch && taken));

endmodule

// File: tb/branch_resolve_unit_test.sv
`timescale 1ns/1ps
module branch_resolve_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] inst = '0;
   logic [63:0] pc = '0, opnd_a = '0, opnd_b = '0;
   logic [7:0]  flags = '0;
   logic [4:0]  rj_idx, rd_idx, link_idx;
   logic        out_valid, taken, is_branch, link_we;
   logic [63:0] next_pc, link_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   branch_resolve_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .inst(inst), .pc(pc),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .flags(flags),
      .rj_idx(rj_idx), .rd_idx(rd_idx), .out_valid(out_valid),
      .next_pc(next_pc), .taken(taken), .is_branch(is_branch),
      .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
   );

   // Behavioural reference: arithmetic on integers, no decode structure shared
   task automatic model(input logic [31:0] w, input logic [63:0] p,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [7:0] f,
                        output logic [63:0] e_npc, output logic e_tk,
                        output logic e_br, output logic e_we,
                        output logic [4:0] e_li, output logic [63:0] e_ld,
                        output string tag);
      logic signed [15:0] s16;
      logic signed [20:0] s21;
      logic signed [25:0] s26;
      longint o16, o21, o26;
      logic [63:0] tgt;
      s16 = w[25:10];
      s21 = {w[4:0], w[25:10]};
      s26 = {w[9:0], w[25:10]};
      o16 = longint'(s16) * 4;
      o21 = longint'(s21) * 4;
      o26 = longint'(s26) * 4;
      e_br = 1; e_tk = 0; e_we = 0; e_li = 0; e_ld = p + 64'd4;
      tgt = p + 64'(o16);
      tag = "R2";
      case (int'(w[31:26]))
         16: begin e_tk = (a == 0); tgt = p + 64'(o21); tag = "R4"; end
         17: begin e_tk = (a != 0); tgt = p + 64'(o21); tag = "R4"; end
         18: begin
            tgt = p + 64'(o21); tag = "R3";
            if (w[9:8] == 2'd0)      e_tk = (f[w[7:5]] == 1'b0);
            else if (w[9:8] == 2'd1) e_tk = (f[w[7:5]] == 1'b1);
            else e_br = 0;
         end
         19: begin
            e_tk = 1; tgt = a + 64'(o16); e_li = w[4:0]; e_we = (w[4:0] != 0);
            tag = (w[4:0] == 0) ? "R12" : "R11";
         end
         20: begin e_tk = 1; tgt = p + 64'(o26); tag = "R9"; end
         21: begin e_tk = 1; tgt = p + 64'(o26); e_li = 1; e_we = 1; tag = "R10"; end
         22: begin e_tk = (a == b); tag = "R5"; end
         23: begin e_tk = (a != b); tag = "R5"; end
         24: begin e_tk = ($signed(a) < $signed(b));  tag = "R6"; end
         25: begin e_tk = ($signed(a) >= $signed(b)); tag = "R6"; end
         26: begin e_tk = (a < b);  tag = "R7"; end
         27: begin e_tk = (a >= b); tag = "R7"; end
         default: e_br = 0;
      endcase
      if (e_br && !e_tk && tag != "R2") tag = {tag, "/R8"};
      e_npc = e_tk ? tgt : p + 64'd4;
   endtask

   // Compare on every clock, 5 ns after the edge
   logic        pv;
   logic [63:0] x_npc, x_ld;
   logic        x_tk, x_br, x_we;
   logic [4:0]  x_li;
   string       x_tag;
   always @(posedge clk) begin
      pv = in_valid && !rst;
      model(inst, pc, opnd_a, opnd_b, flags, x_npc, x_tk, x_br, x_we, x_li, x_ld, x_tag);
      #5;
      if (!done) begin
         n_checks++;
         if (out_valid !== pv) begin
            n_fail++;
            $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, pv);
         end
         if (pv) begin
            n_checks++;
            if ({next_pc, taken, is_branch, link_we, link_idx, link_data} !==
                {x_npc, x_tk, x_br, x_we, x_li, x_ld}) begin
               n_fail++;
               $display("FAIL %s inst=%h actual npc=%h tk=%b br=%b we=%b li=%0d ld=%h expected npc=%h tk=%b br=%b we=%b li=%0d ld=%h",
                        x_tag, inst, next_pc, taken, is_branch, link_we, link_idx, link_data,
                        x_npc, x_tk, x_br, x_we, x_li, x_ld);
            end
         end
      end
   end

   function automatic logic [31:0] enc(input logic [5:0] op, input logic [15:0] hi,
                                       input logic [4:0] j, input logic [4:0] d);
      return {op, hi, j, d};
   endfunction

   task automatic send(input logic [31:0] w, input logic [63:0] p,
                       input logic [63:0] a, input logic [63:0] b, input logic [7:0] f);
      @(negedge clk);
      in_valid = 1; inst = w; pc = p; opnd_a = a; opnd_b = b; flags = f;
      #2;
      n_checks++;
      if (rj_idx !== w[9:5] || rd_idx !== w[4:0]) begin
         n_fail++;
         $display("FAIL R13 idx actual=%0d/%0d expected=%0d/%0d", rj_idx, rd_idx, w[9:5], w[4:0]);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      idle();
      // R4: zero test, negative 21-bit offset, taken and not taken
      send(enc(6'h10, 16'hFFFF, 5'd3, 5'h1F), 64'h1000, 64'd0, 64'd9, 8'h00);
      send(enc(6'h11, 16'h0004, 5'd3, 5'h00), 64'h2000, 64'd0, 64'd0, 8'h00);
      send(enc(6'h11, 16'h8000, 5'd3, 5'h0F), 64'h2000, 64'd5, 64'd0, 8'h00);
      // R3: flag branches, flag 5, both senses, and reserved sub-fields 10/11
      send(enc(6'h12, 16'h0010, 5'b00101, 5'h01), 64'h3000, 64'd0, 64'd0, 8'b0010_0000);
      send(enc(6'h12, 16'h0010, 5'b01101, 5'h01), 64'h3000, 64'd0, 64'd0, 8'b0010_0000);
      send(enc(6'h12, 16'h0010, 5'b10101, 5'h01), 64'h3000, 64'd0, 64'd0, 8'b0000_0000);
      send(enc(6'h12, 16'h0010, 5'b11000, 5'h01), 64'h3000, 64'd0, 64'd0, 8'hFF);
      idle();
      // R5: equality
      send(enc(6'h16, 16'h0100, 5'd1, 5'd2), 64'h4000, 64'hABCD, 64'hABCD, 8'h00);
      send(enc(6'h17, 16'h0100, 5'd1, 5'd2), 64'h4000, 64'hABCD, 64'hABCD, 8'h00);
      // R6/R7: top bits differ so signed and unsigned disagree
      send(enc(6'h18, 16'hFFF0, 5'd1, 5'd2), 64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'h00);
      send(enc(6'h19, 16'hFFF0, 5'd1, 5'd2), 64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'h00);
      send(enc(6'h1A, 16'hFFF0, 5'd1, 5'd2), 64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'h00);
      send(enc(6'h1B, 16'hFFF0, 5'd1, 5'd2), 64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'h00);
      send(enc(6'h19, 16'h0002, 5'd1, 5'd2), 64'h5000, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 8'h00);
      send(enc(6'h1B, 16'h0002, 5'd1, 5'd2), 64'h5000, 64'd7, 64'd7, 8'h00);
      // R9/R10: largest negative and positive 26-bit offsets
      send(enc(6'h14, 16'h0000, 5'b10000, 5'd0), 64'h1_0000_0000, 64'd0, 64'd0, 8'h00);
      send(enc(6'h15, 16'hFFFF, 5'b01111, 5'h1F), 64'h8000, 64'd0, 64'd0, 8'h00);
      // R11/R12: register-indirect jump, link to r5 and to r0
      send(enc(6'h13, 16'h8001, 5'd4, 5'd5), 64'h9000, 64'h0000_7000_0000_0000, 64'd0, 8'h00);
      send(enc(6'h13, 16'h0003, 5'd4, 5'd0), 64'h9000, 64'h1234, 64'd0, 8'h00);
      // R2: non-branch codes at both ends and next to the branch range
      send(32'h0000_0000, 64'hA000, 64'd0, 64'd0, 8'h00);
      send(32'hFFFF_FFFF, 64'hA000, 64'd0, 64'd0, 8'hFF);
      send(enc(6'h0F, 16'h1234, 5'd1, 5'd1), 64'hA000, 64'd0, 64'd0, 8'h00);
      send(enc(6'h1C, 16'h1234, 5'd1, 5'd1), 64'hA000, 64'd0, 64'd0, 8'h00);
      idle(); idle();
      // Mixed pseudo-random traffic with bubbles
      for (int i = 0; i < 600; i++) begin
         logic [31:0] w;
         logic [63:0] a, b;
         w = $urandom;
         if ($urandom_range(0, 3) != 0) w[31:26] = 6'($urandom_range(16, 27));
         a = {$urandom, $urandom};
         b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
         if ($urandom_range(0, 4) == 0) a = 64'd0;
         if ($urandom_range(0, 5) == 0) idle();
         send(w, {$urandom, $urandom}, a, b, 8'($urandom));
      end
      idle();
      // R1: reset in the middle of a stream clears the qualifier
      send(enc(6'h14, 16'h0001, 5'd0, 5'd0), 64'h100, 64'd0, 64'd0, 8'h00);
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0; in_valid = 0;
      idle(); idle();
      finish_run();
   end

   initial begin
      #(20 * 50000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

endmodule